// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading page table entries from memory, one level after another. A requester presents the virtual address together with the physical base address of the top-level table. The walker splits the virtual address into per-level indexes and a page offset. For each level it computes the address of the entry and issues one read on a simple memory read port whose latency may vary. It then follows the entry down to the next table.

When the last level has been read, the walker returns the frame number from that entry joined with the unchanged page offset. An entry whose valid bit is clear ends the walk at once with a fault, and no further reads are made. This lets an outer entry mark a whole unused region as having no inner table.

The walker handles one translation at a time. It is busy from the moment it accepts a request until the cycle in which it presents the result. The number of levels and the index width are parameters. The offset takes whatever bits of the address remain.

Top module: `pgwalk_unit`

## Requirements
- R1: With default parameters the page offset is vaddr[11:0], the level-0 (outer) index is vaddr[31:22] and the level-1 (inner) index is vaddr[21:12].
- R2: Each entry read goes to table base + index * 8. The first read uses req_root as the base.
- R3: In a 64-bit entry, bit 0 is the valid bit and bits [31:12] hold a frame number. Bits [63:32] and [11:1] are ignored. A non-leaf entry gives the next table base as frame number << 12.
- R4: A walk that meets only valid entries makes exactly one read per level. It ends with resp_fault=0 and resp_paddr = {leaf frame number, vaddr[11:0]}.
- R5: An entry with bit 0 clear, at any level, ends the walk with resp_fault=1 and resp_paddr=0, and no further read is issued. An invalid outer entry therefore costs one read.
- R6: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and mem_req_addr does not change.
- R7: req_ready is high exactly when the walker is idle. A req_valid seen while busy is ignored and does not change the walk in progress.
- R8: busy rises the cycle after acceptance and stays high through the single cycle in which resp_valid is high. It is low in the next cycle.
- R9: After reset, busy, resp_valid and mem_req_valid are 0 and req_ready is 1.
- R10: Any number of wait cycles on mem_req_ready and any response delay of one cycle or more give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Physical base address of the top-level table |
| busy | output | 1 | Walk in progress or result being presented |
| resp_valid | output | 1 | One-cycle pulse carrying the result |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
A wrong level counter or a wrong table base shows up on mem_req_addr in the very next read. The bench sees it within a walk as a wrong read count or a wrong physical address in the response. A state machine that fails to stop on an invalid entry shows up as an extra read, or as a fault pulse with a nonzero address. A controller that leaves the idle state wrongly shows up either as a second response, or as req_ready rising in the middle of a walk, one cycle after the error. Table entries with garbage in their ignored bits, and a set of stall and latency patterns, make sure a result never depends on those bits or on timing.

// File: rtl/pgw_pkg.sv
// Shared types for the page table walker.
package pgw_pkg;
    // Walk controller states
    typedef enum logic [1:0] {
        PGW_IDLE  = 2'd0,
        PGW_ISSUE = 2'd1,
        PGW_WAIT  = 2'd2,
        PGW_DONE  = 2'd3
    } pgw_state_e;
endpackage

// File: rtl/pgw_index_sel.sv
// Picks the table index for the current walk level out of the virtual address.
// Assumes: level 0 is the most significant index field; level < LEVELS.
module pgw_index_sel #(
    parameter int VA_W   = 32,
    parameter int LEVELS = 2,
    parameter int IDX_W  = 10,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] index
);
    logic [IDX_W-1:0] field [LEVELS];

    // one slice per level, top field first
    for (genvar l = 0; l < LEVELS; l++) begin : g_field
        assign field[l] = vaddr[VA_W-1-l*IDX_W -: IDX_W];
    end

    // select the slice for the active level
    always_comb begin
        index = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) index = field[l];
        end
    end
endmodule

// File: rtl/pgw_pte_decode.sv
// Splits a table entry into its valid bit and frame number and forms the entry address.
// Assumes: entries are PTE_W bits wide, PTE_W/8 bytes in memory, tables page-aligned.
module pgw_pte_decode #(
    parameter int PA_W  = 32,
    parameter int PTE_W = 64,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int SH    = $clog2(PTE_W / 8)
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] index,
    output logic             pte_valid,
    output logic [PPN_W-1:0] pte_frame,
    output logic [PA_W-1:0]  entry_addr
);
    // field extraction, other bits ignored
    assign pte_valid = pte[0];
    assign pte_frame = pte[OFF_W +: PPN_W];

    // base plus index scaled by entry size
    assign entry_addr = base + (PA_W'(index) << SH);
endmodule

// File: rtl/pgwalk_unit.sv
// Sequential multi-level page table walker: one memory read per level, stops early
// on an invalid entry. Assumes memory returns data at least one cycle after the
// request handshake and only one read is outstanding at a time.
module pgwalk_unit #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int LEVELS = 2,
    parameter int IDX_W  = 10,
    parameter int PTE_W  = 64,
    localparam int OFF_W = VA_W - LEVELS * IDX_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    import pgw_pkg::*;

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    pgw_state_e       state_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  va_q;
    logic             fault_q;
    logic [PA_W-1:0]  paddr_q;

    logic [IDX_W-1:0] cur_index;
    logic             pte_valid;
    logic [PPN_W-1:0] pte_frame;
    logic [PA_W-1:0]  entry_addr;

    pgw_index_sel #(.VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
        .vaddr (va_q),
        .level (level_q),
        .index (cur_index)
    );

    pgw_pte_decode #(.PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec (
        .pte        (mem_rsp_data),
        .base       (base_q),
        .index      (cur_index),
        .pte_valid  (pte_valid),
        .pte_frame  (pte_frame),
        .entry_addr (entry_addr)
    );

    // walk controller: accept, issue, wait, descend or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PGW_IDLE;
            level_q <= '0;
            base_q  <= '0;
            va_q    <= '0;
            fault_q <= 1'b0;
            paddr_q <= '0;
        end else begin
            case (state_q)
                PGW_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        base_q  <= req_root;
                        level_q <= '0;
                        state_q <= PGW_ISSUE;
                    end
                end
                PGW_ISSUE: begin
                    if (mem_req_ready) state_q <= PGW_WAIT;
                end
                PGW_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!pte_valid) begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            state_q <= PGW_DONE;
                        end else if (level_q == LAST_LVL) begin
                            fault_q <= 1'b0;
                            paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
                            state_q <= PGW_DONE;
                        end else begin
                            base_q  <= {pte_frame, {OFF_W{1'b0}}};
                            level_q <= level_q + 1'b1;
                            state_q <= PGW_ISSUE;
                        end
                    end
                end
                default: state_q <= PGW_IDLE;
            endcase
        end
    end

    // port outputs decoded from state and registers
    assign req_ready     = (state_q == PGW_IDLE);
    assign busy          = (state_q != PGW_IDLE);
    assign mem_req_valid = (state_q == PGW_ISSUE);
    assign mem_req_addr  = entry_addr;
    assign resp_valid    = (state_q == PGW_DONE);
    assign resp_fault    = fault_q;
    assign resp_paddr    = paddr_q;

    // R6: stalled request keeps valid and address
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7: never ready while busy
    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R8: response cycle is followed by idle
    assert_resp_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!busy && !resp_valid));

    // R5: fault carries a zero address
    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    // R4: good translation keeps the page offset
    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    // R5: after a response data arrives, no new read in the same walk once finishing
    assert_no_read_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || resp_valid) |-> !mem_req_valid);
endmodule

// File: tb/pgwalk_unit_test.sv
`timescale 1ns/1ps
module pgwalk_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        busy, resp_valid, resp_fault;
    logic [31:0] resp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int rdy_dly = 0;
    int rsp_dly = 0;
    int hold_viol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgwalk_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .busy(busy),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // table contents: bit0 valid, frame in [31:12]; junk in ignored bits (R3)
    function automatic logic [63:0] pte(input logic [31:0] a);
        case (a)
            32'h0010_0000: pte = 64'hDEAD_BEEF_0020_0FF1; // root A, outer 0 -> 0x00200000
            32'h0010_1FF8: pte = 64'h0000_0000_0030_0001; // root A, outer 3FF -> 0x00300000
            32'h0040_0000: pte = 64'h0000_0000_0020_0001; // root B, outer 0 -> 0x00200000
            32'h0020_0000: pte = 64'h1234_0000_ABCD_E001; // inner 0 -> frame ABCDE
            32'h0020_0008: pte = 64'h0000_0000_1234_5001;
            32'h0020_0038: pte = 64'hFFFF_FFFF_FFFF_F000; // invalid
            32'h0030_1FF8: pte = 64'h0000_0000_FFFF_F001;
            32'h0030_1F80: pte = 64'h0000_0000_0005_1001;
            default:       pte = 64'h0;
        endcase
    endfunction

    // memory responder with programmable stall and latency
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] a;
                repeat (rdy_dly) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (rsp_dly) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'h0;
            end
        end
    end

    // observers: read count and request stability (R6)
    logic        pv = 1'b0;
    logic        pr = 1'b0;
    logic [31:0] pa = '0;
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) reads = reads + 1;
        if (rst_n && pv && !pr && (!mem_req_valid || mem_req_addr != pa)) hold_viol = hold_viol + 1;
        pv = mem_req_valid;
        pr = mem_req_ready;
        pa = mem_req_addr;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [31:0] va, input logic [31:0] root);
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (resp_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic        fault;
        logic [31:0] pa;
        logic [3:0]  nreads;
        logic [3:0]  rdly;
        logic [3:0]  sdly;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0ABC, 32'h0010_0000, 1'b0, 32'hABCD_EABC, 4'd2, 4'd0, 4'd0}, // R1 R4
        '{32'h0000_1123, 32'h0010_0000, 1'b0, 32'h1234_5123, 4'd2, 4'd2, 4'd1}, // R1 R10
        '{32'hFFFF_FFFF, 32'h0010_0000, 1'b0, 32'hFFFF_FFFF, 4'd2, 4'd0, 4'd3}, // R2 R4
        '{32'hFFFF_0008, 32'h0010_0000, 1'b0, 32'h0005_1008, 4'd2, 4'd1, 4'd0}, // R1 R2
        '{32'h0140_0000, 32'h0010_0000, 1'b1, 32'h0000_0000, 4'd1, 4'd0, 4'd0}, // R5 outer
        '{32'h0000_7FFF, 32'h0010_0000, 1'b1, 32'h0000_0000, 4'd2, 4'd3, 4'd2}, // R5 inner
        '{32'h0000_0555, 32'h0040_0000, 1'b0, 32'hABCD_E555, 4'd2, 4'd0, 4'd0}, // R2 root
        '{32'h0040_0000, 32'h0040_0000, 1'b1, 32'h0000_0000, 4'd1, 4'd4, 4'd4}  // R5 R10
    };

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!busy && req_ready && !resp_valid && !mem_req_valid, "R9 reset state",
            {busy, req_ready, resp_valid, mem_req_valid}, 4'b0100);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            rdy_dly = int'(VEC[v].rdly);
            rsp_dly = int'(VEC[v].sdly);
            start(VEC[v].va, VEC[v].root);
            chk(busy && !req_ready, "R8 busy after accept", {busy, req_ready}, 2'b10);
            wait_resp(seen);
            chk(seen, "R10 response seen", seen, 1);
            chk(resp_fault == VEC[v].fault, VEC[v].fault ? "R5 fault flag" : "R4 fault flag",
                resp_fault, VEC[v].fault);
            chk(resp_paddr == VEC[v].pa, VEC[v].fault ? "R5 zero address" : "R4 physical address",
                resp_paddr, VEC[v].pa);
            chk(reads == int'(VEC[v].nreads), VEC[v].fault ? "R5 reads before stop" : "R4 one read per level",
                reads, VEC[v].nreads);
            chk(busy, "R8 busy during response", busy, 1);
            @(negedge clk);
            chk(!busy && !resp_valid && req_ready, "R8 idle after response",
                {busy, resp_valid, req_ready}, 3'b001);
        end

        // R7: requests during a walk are ignored
        rdy_dly = 3;
        rsp_dly = 2;
        start(32'h0000_1123, 32'h0010_0000);
        req_valid = 1'b1;
        req_vaddr = 32'hFFFF_FFFF;
        req_root  = 32'h0040_0000;
        repeat (3) @(negedge clk);
        chk(!req_ready, "R7 not ready while busy", req_ready, 0);
        req_valid = 1'b0;
        wait_resp(seen);
        chk(seen && !resp_fault && resp_paddr == 32'h1234_5123, "R7 walk unaffected",
            resp_paddr, 32'h1234_5123);
        @(negedge clk);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (resp_valid || busy) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R7 no second walk", seen, 0);
        chk(reads == 2, "R7 no extra reads", reads, 2);

        // R6: stalled requests held (observed over whole run)
        chk(hold_viol == 0, "R6 request held while stalled", hold_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule